// File: doc/BRIEF.md
# Virtual Interrupt List-Register Lookup

This block keeps a small bank of list registers for every physical CPU interface. Each 32-bit entry describes one virtual interrupt: its virtual ID, a linked physical or source-CPU ID, a 5-bit priority, a 2-bit life-cycle state, a group bit and a hardware-link flag. A write port loads one entry of one bank per clock edge. A query port names an interface index and a virtual interrupt ID. From these two inputs the block answers two questions within the same cycle, with no clock edge in between.

The check answer says whether the queried interrupt is already acknowledged, meaning an entry with that ID is in an active state. It guards end-of-interrupt and deactivation requests. The lookup answer gives the index and the decoded fields of the lowest-numbered entry that holds the ID in any state other than invalid. Interface indices from the CPU count upward address the virtual interfaces, and these share the bank of the matching physical CPU.

The per-entry state is an enumeration with four named values: idle (invalid), pending, active and active-pending. The block holds no control sequencer. Its only "transitions" are writes, which move an entry from any state to any other state, and reset, which moves every entry to idle.

Top module: `vlr_lookup`

## Requirements
- R1: After reset every entry is idle, so every query reports `lu_miss`=1, `chk_active`=0 and `lu_idx`=0.
- R2: A write with `wr_en`=1 replaces entry `wr_lr` of bank `wr_cpu` at the next rising clock edge. Before that edge, queries still see the old contents.
- R3: The state field is bits 29:28, coded 0 idle, 1 pending, 2 active, 3 active-pending. `chk_active` is 1 exactly when some entry of the selected bank has virtual ID (bits 9:0) equal to `q_id` and has state bit 1 set.
- R4: The lookup matches an entry whose virtual ID equals `q_id` and whose state is not 0. On a match, `lu_miss`=0 and `lu_state` gives that entry's state.
- R5: When several entries match the lookup, `lu_idx` and all decoded fields come from the lowest-indexed match.
- R6: A `q_iface` below NUM_CPU selects bank `q_iface`. A `q_iface` of NUM_CPU or more selects bank `q_iface`-NUM_CPU.
- R7: With no lookup match, `lu_miss`=1, `lu_idx`=0 and every decoded field output is 0.
- R8: `lu_prio` is the 5-bit field in bits 27:23 shifted left by three places, which makes an 8-bit value with its low three bits at 0.
- R9: The decoded fields are taken from fixed bit positions. `lu_vid` is bits 9:0. `lu_pid` is bits 19:10. `lu_src_cpu` is bits 12:10. `lu_grp` is bit 30. `lu_hw` is bit 31. `lu_eoi` is bit 19 when bit 31 is 0, and 0 otherwise.
- R10: Query results are combinational. Changing `q_iface` or `q_id` changes the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all entries |
| wr_en | input | 1 | Entry write strobe |
| wr_cpu | input | CPU_W | Bank (physical CPU) to write |
| wr_lr | input | LR_W | Entry index within the bank |
| wr_data | input | 32 | New entry contents |
| q_iface | input | IF_W | Queried interface index (physical or virtual) |
| q_id | input | 10 | Queried virtual interrupt ID |
| chk_active | output | 1 | Queried ID is acknowledged (active or active-pending) |
| lu_miss | output | 1 | No live entry holds the queried ID |
| lu_idx | output | LR_W | Index of the matched entry |
| lu_vid | output | 10 | Matched virtual ID |
| lu_pid | output | 10 | Matched physical ID field |
| lu_src_cpu | output | 3 | Matched source CPU field |
| lu_eoi | output | 1 | Matched end-of-interrupt request flag |
| lu_prio | output | 8 | Matched priority, scaled by 8 |
| lu_state | output | 2 | Matched state |
| lu_grp | output | 1 | Matched group bit |
| lu_hw | output | 1 | Matched hardware-link flag |

## Verification
A write and a query can address the same entry in the same cycle, so the lookup and the storage update collide. The bench provokes this by driving a write and a matching query together. It requires a miss before the clock edge and a hit on the new contents after it. Duplicate IDs are common in the sweep, because virtual IDs are drawn from only six values. This tests the check and the lookup on the same bank at once, and each of them is judged against a model that scans the bench's own copy of the entries.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    localparam int VID_W  = 10;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        LR_IDLE     = 2'd0,
        LR_PEND     = 2'd1,
        LR_ACT      = 2'd2,
        LR_ACT_PEND = 2'd3
    } lr_state_e;

    // Stored entry layout, MSB first
    typedef struct packed {
        logic             hw;
        logic             grp;
        lr_state_e        st;
        logic [4:0]       prio;
        logic [2:0]       rsvd;
        logic [9:0]       mid;
        logic [VID_W-1:0] vid;
    } lr_word_t;

    typedef struct packed {
        logic [VID_W-1:0] vid;
        logic [9:0]       pid;
        logic [2:0]       cpu;
        logic             eoi;
        logic [7:0]       prio;
        lr_state_e        st;
        logic             grp;
        logic             hw;
    } lr_view_t;

    function automatic logic lr_is_live(lr_state_e s);
        logic r;
        unique case (s)
            LR_IDLE:     r = 1'b0;
            LR_PEND:     r = 1'b1;
            LR_ACT:      r = 1'b1;
            LR_ACT_PEND: r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic lr_is_acked(lr_state_e s);
        logic r;
        unique case (s)
            LR_IDLE:     r = 1'b0;
            LR_PEND:     r = 1'b0;
            LR_ACT:      r = 1'b1;
            LR_ACT_PEND: r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic lr_view_t lr_decode(lr_word_t w);
        lr_view_t v;
        v.vid  = w.vid;
        v.pid  = w.mid;
        v.cpu  = w.mid[2:0];
        v.eoi  = w.mid[9] & ~w.hw;
        v.prio = {w.prio, 3'b000};
        v.st   = w.st;
        v.grp  = w.grp;
        v.hw   = w.hw;
        return v;
    endfunction

endpackage

// File: rtl/vlr_bank.sv
module vlr_bank
    import vlr_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_LR  = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int LR_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_W-1:0]  wr_cpu,
    input  logic [LR_W-1:0]   wr_lr,
    input  logic [WORD_W-1:0] wr_data,
    output lr_word_t          bank_q [NUM_CPU][NUM_LR]
);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar l = 0; l < NUM_LR; l++) begin : g_lr
            logic hit_wr;
            assign hit_wr = wr_en && (wr_cpu == CPU_W'(c)) && (wr_lr == LR_W'(l));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank_q[c][l] <= '0;
                end else if (hit_wr) begin
                    bank_q[c][l] <= lr_word_t'(wr_data);
                end
            end
        end
    end

    logic all_idle;
    always_comb begin
        all_idle = 1'b1;
        for (int c = 0; c < NUM_CPU; c++)
            for (int l = 0; l < NUM_LR; l++)
                if (bank_q[c][l].st != LR_IDLE) all_idle = 1'b0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> all_idle);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_cpu) < NUM_CPU && int'(wr_lr) < NUM_LR) |=>
        (bank_q[$past(wr_cpu)][$past(wr_lr)] == lr_word_t'($past(wr_data))));

endmodule

// File: rtl/vlr_select.sv
module vlr_select
    import vlr_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_LR  = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IF_W   = $clog2(2 * NUM_CPU)
) (
    input  lr_word_t         bank_q [NUM_CPU][NUM_LR],
    input  logic [IF_W-1:0]  q_iface,
    output lr_word_t         row    [NUM_LR]
);

    logic [IF_W-1:0] phys;
    logic            in_range;

    always_comb begin
        phys     = (q_iface >= IF_W'(NUM_CPU)) ? (q_iface - IF_W'(NUM_CPU)) : q_iface;
        in_range = (int'(phys) < NUM_CPU);
        for (int l = 0; l < NUM_LR; l++) begin
            row[l] = in_range ? bank_q[phys[CPU_W-1:0]][l] : '0;
        end
    end

endmodule

// File: rtl/vlr_search.sv
module vlr_search
    import vlr_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int LR_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lr_word_t         row [NUM_LR],
    input  logic [VID_W-1:0] q_id,
    output logic             any_acked,
    output logic             found,
    output logic [LR_W-1:0]  idx,
    output lr_word_t         sel
);

    logic [NUM_LR-1:0] live_m;
    logic [NUM_LR-1:0] ack_m;

    for (genvar l = 0; l < NUM_LR; l++) begin : g_cmp
        logic id_eq;
        assign id_eq     = (row[l].vid == q_id);
        assign live_m[l] = id_eq && lr_is_live(row[l].st);
        assign ack_m[l]  = id_eq && lr_is_acked(row[l].st);
    end

    assign any_acked = |ack_m;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int l = NUM_LR - 1; l >= 0; l--) begin
            if (live_m[l]) begin
                found = 1'b1;
                idx   = LR_W'(l);
            end
        end
        sel = found ? row[idx] : '0;
    end

    logic [NUM_LR-1:0] below_mask;
    assign below_mask = (NUM_LR'(1) << idx) - NUM_LR'(1);

    // R5
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((live_m & below_mask) == '0));

    // R7
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (idx == '0 && sel == '0));

    // R4
    sel_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (sel.vid == q_id && sel.st != LR_IDLE));

endmodule

// File: rtl/vlr_lookup.sv
module vlr_lookup
    import vlr_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_LR  = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int LR_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int IF_W   = $clog2(2 * NUM_CPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_W-1:0]  wr_cpu,
    input  logic [LR_W-1:0]   wr_lr,
    input  logic [31:0]       wr_data,
    input  logic [IF_W-1:0]   q_iface,
    input  logic [9:0]        q_id,
    output logic              chk_active,
    output logic              lu_miss,
    output logic [LR_W-1:0]   lu_idx,
    output logic [9:0]        lu_vid,
    output logic [9:0]        lu_pid,
    output logic [2:0]        lu_src_cpu,
    output logic              lu_eoi,
    output logic [7:0]        lu_prio,
    output logic [1:0]        lu_state,
    output logic              lu_grp,
    output logic              lu_hw
);

    lr_word_t bank_q [NUM_CPU][NUM_LR];
    lr_word_t row    [NUM_LR];
    lr_word_t sel;
    lr_view_t view;
    logic     found;

    vlr_bank #(.NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_cpu  (wr_cpu),
        .wr_lr   (wr_lr),
        .wr_data (wr_data),
        .bank_q  (bank_q)
    );

    vlr_select #(.NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR)) u_select (
        .bank_q  (bank_q),
        .q_iface (q_iface),
        .row     (row)
    );

    vlr_search #(.NUM_LR(NUM_LR)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .row       (row),
        .q_id      (q_id),
        .any_acked (chk_active),
        .found     (found),
        .idx       (lu_idx),
        .sel       (sel)
    );

    always_comb begin
        view       = lr_decode(sel);
        lu_miss    = !found;
        lu_vid     = view.vid;
        lu_pid     = view.pid;
        lu_src_cpu = view.cpu;
        lu_eoi     = view.eoi;
        lu_prio    = view.prio;
        lu_state   = view.st;
        lu_grp     = view.grp;
        lu_hw      = view.hw;
    end

    // R3
    acked_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_active |-> !lu_miss);

    // R8
    prio_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lu_prio[2:0] == 3'b000);

    // R9
    eoi_hw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lu_eoi && lu_hw));

endmodule

// File: tb/test_vlr_lookup.sv
module test_vlr_lookup;

    localparam int NCPU = 2;
    localparam int NLR  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_cpu = '0;
    logic [1:0]  wr_lr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  q_iface = '0;
    logic [9:0]  q_id = '0;
    logic        chk_active, lu_miss, lu_eoi, lu_grp, lu_hw;
    logic [1:0]  lu_idx, lu_state;
    logic [9:0]  lu_vid, lu_pid;
    logic [2:0]  lu_src_cpu;
    logic [7:0]  lu_prio;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] mdl [NCPU][NLR];

    always #5 clk = ~clk;

    vlr_lookup #(.NUM_CPU(NCPU), .NUM_LR(NLR)) i_vlr_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_lr(wr_lr),
        .wr_data(wr_data), .q_iface(q_iface), .q_id(q_id),
        .chk_active(chk_active), .lu_miss(lu_miss), .lu_idx(lu_idx),
        .lu_vid(lu_vid), .lu_pid(lu_pid), .lu_src_cpu(lu_src_cpu), .lu_eoi(lu_eoi),
        .lu_prio(lu_prio), .lu_state(lu_state), .lu_grp(lu_grp), .lu_hw(lu_hw)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_lr(input int c, input int l, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_cpu = 1'(c); wr_lr = 2'(l); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[c][l] = d;
    endtask

    // Expected result from the bench copy of the entries
    task automatic query_and_check(input int ifc, input int id);
        int bank;
        bit exp_ok, exp_hit;
        int exp_idx;
        logic [31:0] d;
        logic [63:0] exp_f, act_f;
        bank = (ifc >= NCPU) ? ifc - NCPU : ifc;
        exp_ok = 0; exp_hit = 0; exp_idx = 0; d = '0;
        for (int l = 0; l < NLR; l++) begin
            if (int'(mdl[bank][l][9:0]) == id && mdl[bank][l][29]) exp_ok = 1;
            if (!exp_hit && int'(mdl[bank][l][9:0]) == id && mdl[bank][l][29:28] != 2'd0) begin
                exp_hit = 1; exp_idx = l; d = mdl[bank][l];
            end
        end
        @(negedge clk);
        q_iface = 2'(ifc); q_id = 10'(id);
        #2;
        check(chk_active == exp_ok, "R3 check", 64'(chk_active), 64'(exp_ok));
        check(lu_miss == !exp_hit, "R4 miss", 64'(lu_miss), 64'(!exp_hit));
        check(int'(lu_idx) == exp_idx, (ifc >= NCPU) ? "R6 idx" : "R5 idx", 64'(lu_idx), 64'(exp_idx));
        if (exp_hit) begin
            exp_f = {d[9:0], d[19:10], d[12:10], d[19] & ~d[31], d[30], d[31], d[29:28]};
            act_f = {lu_vid, lu_pid, lu_src_cpu, lu_eoi, lu_grp, lu_hw, lu_state};
            check(act_f == exp_f, "R9 fields", act_f, exp_f);
            check(lu_prio == 8'(d[27:23]) * 8'd8, "R8 prio", 64'(lu_prio), 64'(8'(d[27:23]) * 8'd8));
        end else begin
            act_f = {lu_vid, lu_pid, lu_src_cpu, lu_eoi, lu_prio, lu_state, lu_grp, lu_hw};
            check(act_f == 0, "R7 zero fields", act_f, 64'd0);
        end
    endtask

    initial begin
        for (int c = 0; c < NCPU; c++)
            for (int l = 0; l < NLR; l++) mdl[c][l] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int ifc = 0; ifc < 2 * NCPU; ifc++)
            for (int id = 0; id < 4; id++) begin
                @(negedge clk);
                q_iface = 2'(ifc); q_id = 10'(id);
                #2;
                check(lu_miss && !chk_active && lu_idx == 0, "R1 reset", {lu_miss, chk_active, lu_idx}, 64'b1000);
            end

        // R2 write and query on one entry in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_cpu = 1'b1; wr_lr = 2'd2; wr_data = 32'h1080_0007;
        q_iface = 2'd3; q_id = 10'd7;
        #2;
        check(lu_miss == 1'b1, "R2 before edge", 64'(lu_miss), 64'd1);
        @(posedge clk); #2;
        wr_en = 1'b0;
        mdl[1][2] = 32'h1080_0007;
        check(!lu_miss && lu_idx == 2'd2, "R2 after edge", {lu_miss, lu_idx}, 64'd2);

        // R10 combinational response without a clock edge
        @(negedge clk);
        q_id = 10'd6; #1;
        check(lu_miss == 1'b1, "R10 id change", 64'(lu_miss), 64'd1);
        q_id = 10'd7; #1;
        check(lu_miss == 1'b0, "R10 id back", 64'(lu_miss), 64'd0);

        // Main sweep: IDs 0..5 give frequent duplicates
        for (int p = 0; p < 48; p++) begin
            for (int c = 0; c < NCPU; c++)
                for (int l = 0; l < NLR; l++) begin
                    logic [31:0] h;
                    h = 32'(p * 32'h9E37_79B1) ^ 32'((c * 7 + l + 1) * 32'h85EB_CA6B);
                    h[9:0] = 10'((p + l * 3 + c * 5 + (p >> 2)) % 6);
                    write_lr(c, l, h);
                end
            for (int ifc = 0; ifc < 2 * NCPU; ifc++)
                for (int id = 0; id < 7; id++) query_and_check(ifc, id);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule